// File: doc/BRIEF.md
# Flash Command Sequencer with Erase Suspend

This block drives operations on an embedded flash array from a small register interface. Software writes a target address (two 16-bit halves), a 32-bit data word (two 16-bit halves) and a control word that names one operation: a word program, a sector erase or a write of the protection word. Setting the launch bit in the control word starts the operation. A behavioural array model with fixed busy durations sits inside the block. Programming can only clear bits in that model. Erasing sets a whole sector back to all ones.

A running sector erase can be paused with the suspend bit. While it is paused, one word program can run at a time. The erase then continues from where it stopped once software sets the sector-erase bit again. The block rejects illegal control combinations and raises an error flag for them. Status outputs show when the block is busy, when an erase is paused, and the control word as it is currently stored.

Top module: `fcs_sequencer`

## Requirements
- R1: After reset, busy, suspended and err are 0, ctl_o is 0, every array word reads all ones and prot_word is all ones.
- R2: From idle, a control write with bit 15 and bit 0 set (no other operation bit set, bit 2 clear) and a valid address starts a word program. busy is high for PROG_CYC cycles. At completion the addressed word becomes old AND {data_hi,data_lo}, and bit 15 of ctl_o reads 0.
- R3: From idle, a control write with bit 15 and bit 1 set starts a sector erase. busy is high for ERASE_CYC cycles. At completion every word of the sector (word index >> SECT_W) reads all ones.
- R4: From idle, a control write with bit 15 and bit 8 set runs a protection write for PROG_CYC busy cycles. prot_word becomes old AND data, and the address is not checked. prot_word never gains a 1 bit.
- R5: A control write with bit 2 set during an erase (not in its last cycle) pauses it. From the next cycle busy is 0 and suspended is 1. The remaining erase count does not change while the erase is paused.
- R6: While paused, a control write with bit 15 and bit 0 set, and bits 1, 2 and 8 clear, runs a word program. busy and suspended are both high for PROG_CYC cycles. Only the target word changes, and the block then returns to the paused state.
- R7: While paused and not busy, a control write with bit 1 set and bits 0, 2 and 8 clear resumes the erase. The busy, non-paused cycles of the erase add up to ERASE_CYC, and the sector ends all ones.
- R8: A control write with bits 15 and 2 both set, in idle or while paused, starts nothing. It sets err, leaves the array unchanged, and stores the written value with bit 15 cleared.
- R9: A launch is also rejected, with err set, when it names zero operations or more than one. It is rejected when a program or erase address is out of range. It is rejected when a paused erase is given a launch other than a word program.
- R10: err is cleared by every accepted launch and by a resume. A control write without bit 15 leaves err as it is and is stored in ctl_o.
- R11: While busy, all register writes are ignored. The one exception is a control write with bit 2 set during a running erase. A suspend during a program has no effect.
- R12: Register select: 0 is control, 1 is address low, 2 is address high, 3 is data low, 4 is data high. An address is valid when address high is 0 and address-low bits above the word index are 0. The word index is address low [SECT_W+SECT_NUM_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (R12) |
| reg_wdata | input | 16 | Register write data |
| rd_addr | input | SECT_W+SECT_NUM_W | Array word index for reading |
| rd_data | output | 32 | Array word at rd_addr |
| prot_word | output | 32 | Protection word |
| ctl_o | output | 16 | Stored control word |
| busy | output | 1 | An operation is running |
| suspended | output | 1 | A sector erase is paused |
| err | output | 1 | Last launch or control command was rejected |

## Verification
Each kind of operation is first run from idle with directed addresses and data. This separates the AND-only program effect from the whole-sector erase effect, and checks that the protection word ignores the address. A full pause sequence follows: pause, a forbidden launch with suspend still set, a program into another sector, a forbidden protection launch, then resume. This shows that the erase count is frozen, that only the target word changes, and that the latched sector is erased after resume. Random launches, including random control words and out-of-range addresses, are then checked against bench functions for the verdict, the busy length, err and the array image. Writes made during busy periods show that the stored address is not overwritten.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
    // control word bit positions
    localparam int CB_GO   = 15;
    localparam int CB_PROT = 8;
    localparam int CB_SUSP = 2;
    localparam int CB_SER  = 1;
    localparam int CB_WPG  = 0;

    localparam logic [2:0] SEL_CTL = 3'd0;
    localparam logic [2:0] SEL_ALO = 3'd1;
    localparam logic [2:0] SEL_AHI = 3'd2;
    localparam logic [2:0] SEL_DLO = 3'd3;
    localparam logic [2:0] SEL_DHI = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_PROT, ST_ERASE, ST_ESUSP, ST_SPROG
    } fsm_e;

    typedef enum logic [2:0] {
        VD_STORE, VD_IGNORE, VD_PROG, VD_ERASE, VD_PROT,
        VD_SUSPEND, VD_RESUME, VD_REJECT
    } verdict_e;
endpackage

// File: rtl/fcs_cmd_decode.sv
`timescale 1ns/1ps
module fcs_cmd_decode
    import fcs_pkg::*;
(
    input  logic     go,
    input  logic     susp,
    input  logic     ser,
    input  logic     wpg,
    input  logic     prw,
    input  fsm_e     state,
    input  logic     addr_ok,
    output verdict_e verdict
);
    logic [1:0] nops;

    always_comb begin
        nops    = {1'b0, wpg} + {1'b0, ser} + {1'b0, prw};
        verdict = VD_STORE;
        case (state)
            ST_ERASE: verdict = susp ? VD_SUSPEND : VD_IGNORE;
            ST_PROG, ST_PROT, ST_SPROG: verdict = VD_IGNORE;
            ST_ESUSP: begin
                if (go) begin
                    verdict = (!susp && wpg && !ser && !prw && addr_ok) ? VD_PROG : VD_REJECT;
                end else if (ser && !susp && !wpg && !prw) begin
                    verdict = VD_RESUME;
                end
            end
            default: begin
                if (go) begin
                    if (susp || nops != 2'd1 || ((wpg || ser) && !addr_ok)) verdict = VD_REJECT;
                    else if (wpg) verdict = VD_PROG;
                    else if (ser) verdict = VD_ERASE;
                    else          verdict = VD_PROT;
                end
            end
        endcase
    end
endmodule

// File: rtl/fcs_flash_model.sv
`timescale 1ns/1ps
module fcs_flash_model #(
    parameter int SECT_W     = 3,
    parameter int SECT_NUM_W = 2,
    parameter int DW         = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pgm_en,
    input  logic [SECT_W+SECT_NUM_W-1:0] pgm_idx,
    input  logic [DW-1:0]                pgm_data,
    input  logic                         ers_en,
    input  logic [SECT_NUM_W-1:0]        ers_sect,
    input  logic [SECT_W+SECT_NUM_W-1:0] rd_idx,
    output logic [DW-1:0]                rd_data
);
    localparam int IDX_W = SECT_W + SECT_NUM_W;
    localparam int WORDS = 1 << IDX_W;

    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] mem_d [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
            if (ers_en && ((i >> SECT_W) == int'(ers_sect))) mem_d[i] = '1;
        end
        // programming only clears bits
        if (pgm_en) mem_d[pgm_idx] = mem_q[pgm_idx] & pgm_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) mem_q[i] <= '1;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/fcs_sequencer.sv
`timescale 1ns/1ps
module fcs_sequencer
    import fcs_pkg::*;
#(
    parameter int SECT_W     = 3,
    parameter int SECT_NUM_W = 2,
    parameter int PROG_CYC   = 4,
    parameter int ERASE_CYC  = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [2:0]                   reg_sel,
    input  logic [15:0]                  reg_wdata,
    input  logic [SECT_W+SECT_NUM_W-1:0] rd_addr,
    output logic [31:0]                  rd_data,
    output logic [31:0]                  prot_word,
    output logic [15:0]                  ctl_o,
    output logic                         busy,
    output logic                         suspended,
    output logic                         err
);
    localparam int IDX_W   = SECT_W + SECT_NUM_W;
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        fsm_e                  st;
        logic [15:0]           ctl;
        logic [15:0]           alo;
        logic [15:0]           ahi;
        logic [15:0]           dlo;
        logic [15:0]           dhi;
        logic [CNT_W-1:0]      pcnt;
        logic [CNT_W-1:0]      eleft;
        logic [SECT_NUM_W-1:0] esect;
        logic [31:0]           prot;
        logic                  err;
    } regs_t;

    regs_t    q, n;
    verdict_e verdict;
    logic     ctl_we, addr_ok, pgm_en, ers_en;
    logic     erasing;
    logic [CNT_W-1:0] eleft_mon;
    logic [15:0]      alo_mon;

    assign addr_ok = (q.ahi == '0) && (q.alo[15:IDX_W] == '0);
    assign ctl_we  = reg_we && (reg_sel == SEL_CTL);

    fcs_cmd_decode u_dec (
        .go     (reg_wdata[CB_GO]),
        .susp   (reg_wdata[CB_SUSP]),
        .ser    (reg_wdata[CB_SER]),
        .wpg    (reg_wdata[CB_WPG]),
        .prw    (reg_wdata[CB_PROT]),
        .state  (q.st),
        .addr_ok(addr_ok),
        .verdict(verdict)
    );

    always_comb begin
        n      = q;
        pgm_en = 1'b0;
        ers_en = 1'b0;

        if (reg_we && !busy) begin
            case (reg_sel)
                SEL_ALO: n.alo = reg_wdata;
                SEL_AHI: n.ahi = reg_wdata;
                SEL_DLO: n.dlo = reg_wdata;
                SEL_DHI: n.dhi = reg_wdata;
                default: ;
            endcase
        end

        case (q.st)
            ST_PROG, ST_SPROG, ST_PROT: begin
                if (q.pcnt == CNT_W'(1)) begin
                    if (q.st == ST_PROT) n.prot = q.prot & {q.dhi, q.dlo};
                    else                 pgm_en = 1'b1;
                    n.st        = (q.st == ST_SPROG) ? ST_ESUSP : ST_IDLE;
                    n.ctl[CB_GO] = 1'b0;
                end else begin
                    n.pcnt = q.pcnt - CNT_W'(1);
                end
            end
            ST_ERASE: begin
                if (q.eleft == CNT_W'(1)) begin
                    ers_en       = 1'b1;
                    n.st         = ST_IDLE;
                    n.ctl[CB_GO] = 1'b0;
                end else begin
                    // the cycle that carries a suspend still counts as erase work
                    n.eleft = q.eleft - CNT_W'(1);
                    if (ctl_we && verdict == VD_SUSPEND) begin
                        n.st             = ST_ESUSP;
                        n.ctl            = reg_wdata;
                        n.ctl[CB_GO]     = 1'b0;
                    end
                end
            end
            default: ;
        endcase

        if (ctl_we) begin
            case (verdict)
                VD_STORE: n.ctl = reg_wdata;
                VD_PROG: begin
                    n.ctl  = reg_wdata;
                    n.st   = (q.st == ST_ESUSP) ? ST_SPROG : ST_PROG;
                    n.pcnt = CNT_W'(PROG_CYC);
                    n.err  = 1'b0;
                end
                VD_PROT: begin
                    n.ctl  = reg_wdata;
                    n.st   = ST_PROT;
                    n.pcnt = CNT_W'(PROG_CYC);
                    n.err  = 1'b0;
                end
                VD_ERASE: begin
                    n.ctl   = reg_wdata;
                    n.st    = ST_ERASE;
                    n.eleft = CNT_W'(ERASE_CYC);
                    n.esect = q.alo[IDX_W-1:SECT_W];
                    n.err   = 1'b0;
                end
                VD_RESUME: begin
                    n.ctl = reg_wdata;
                    n.st  = ST_ERASE;
                    n.err = 1'b0;
                end
                VD_REJECT: begin
                    n.ctl        = reg_wdata;
                    n.ctl[CB_GO] = 1'b0;
                    n.err        = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.prot <= '1;
        end else begin
            q <= n;
        end
    end

    fcs_flash_model #(
        .SECT_W    (SECT_W),
        .SECT_NUM_W(SECT_NUM_W),
        .DW        (32)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .pgm_en  (pgm_en),
        .pgm_idx (q.alo[IDX_W-1:0]),
        .pgm_data({q.dhi, q.dlo}),
        .ers_en  (ers_en),
        .ers_sect(q.esect),
        .rd_idx  (rd_addr),
        .rd_data (rd_data)
    );

    assign busy      = (q.st == ST_PROG) || (q.st == ST_PROT) ||
                       (q.st == ST_ERASE) || (q.st == ST_SPROG);
    assign suspended = (q.st == ST_ESUSP) || (q.st == ST_SPROG);
    assign err       = q.err;
    assign ctl_o     = q.ctl;
    assign prot_word = q.prot;
    assign erasing   = (q.st == ST_ERASE);
    assign eleft_mon = q.eleft;
    assign alo_mon   = q.alo;
endmodule

// File: rtl/fcs_checker.sv
`timescale 1ns/1ps
module fcs_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_sel,
    input logic [15:0]      reg_wdata,
    input logic             busy,
    input logic             suspended,
    input logic             err,
    input logic [31:0]      prot_word,
    input logic [15:0]      ctl_o,
    input logic             erasing,
    input logic [CNT_W-1:0] eleft,
    input logic [15:0]      alo
);
    logic ctl_wr;
    assign ctl_wr = reg_we && (reg_sel == 3'd0);

    a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> (!suspended || eleft == $past(eleft)));

    a_r5_suspend_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing && eleft > CNT_W'(1) && ctl_wr && reg_wdata[2]) |=> (suspended && !busy));

    a_r8_go_with_susp: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && reg_wdata[15] && reg_wdata[2]) |=> (err && !ctl_o[15] && !busy));

    a_r4_prot_clears_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((prot_word & ~$past(prot_word)) == 32'd0));

    a_r6_prog_returns_paused: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && suspended) |=> suspended);

    a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(alo));
endmodule

bind fcs_sequencer fcs_checker #(.CNT_W(CNT_W)) u_fcs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .busy     (busy),
    .suspended(suspended),
    .err      (err),
    .prot_word(prot_word),
    .ctl_o    (ctl_o),
    .erasing  (erasing),
    .eleft    (eleft_mon),
    .alo      (alo_mon)
);

// File: tb/tb_fcs_sequencer.sv
`timescale 1ns/1ps
module tb_fcs_sequencer;
    localparam int SW    = 3;
    localparam int SNW   = 2;
    localparam int IDXW  = SW + SNW;
    localparam int WORDS = 1 << IDXW;
    localparam int PC    = 4;
    localparam int EC    = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [IDXW-1:0] rd_addr = '0;
    logic [31:0] rd_data, prot_word;
    logic [15:0] ctl_o;
    logic        busy, suspended, err;

    fcs_sequencer #(.SECT_W(SW), .SECT_NUM_W(SNW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .prot_word(prot_word), .ctl_o(ctl_o),
        .busy(busy), .suspended(suspended), .err(err)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int bcnt   = 0;
    bit done   = 1'b0;
    logic [31:0] ref_mem [WORDS];
    logic [31:0] ref_prot;
    logic        ref_err;
    logic [15:0] cur_alo, cur_ahi, cur_dlo, cur_dhi;

    // busy, non-paused cycles, sampled mid-cycle
    always @(posedge clk) begin
        #2;
        if (busy && !suspended) bcnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        if (!busy || sel == 3'd0) begin
            case (sel)
                3'd1: cur_alo = val;
                3'd2: cur_ahi = val;
                3'd3: cur_dlo = val;
                3'd4: cur_dhi = val;
                default: ;
            endcase
        end
    endtask

    task automatic load(input logic [15:0] alo, ahi, dlo, dhi);
        wr(3'd1, alo); wr(3'd2, ahi); wr(3'd3, dlo); wr(3'd4, dhi);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_array(input string req);
        logic [31:0] bad_act = '0, bad_exp = '0;
        bit ok = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            rd_addr = IDXW'(i);
            @(negedge clk);
            if (ok && rd_data !== ref_mem[i]) begin
                ok = 1'b0; bad_act = rd_data; bad_exp = ref_mem[i];
            end
        end
        chk(req, ok ? 32'd0 : bad_act, ok ? 32'd0 : bad_exp);
    endtask

    function automatic bit addr_valid(input logic [15:0] alo, input logic [15:0] ahi);
        return (ahi == 16'd0) && ((alo >> IDXW) == 16'd0);
    endfunction

    // 0 store, 1 program, 2 erase, 3 protection, 4 reject (idle context)
    function automatic int idle_verdict(input logic [15:0] v, input logic [15:0] alo, input logic [15:0] ahi);
        int nops;
        if (!v[15]) return 0;
        nops = int'(v[0]) + int'(v[1]) + int'(v[8]);
        if (v[2] || nops != 1) return 4;
        if ((v[0] || v[1]) && !addr_valid(alo, ahi)) return 4;
        if (v[0]) return 1;
        if (v[1]) return 2;
        return 3;
    endfunction

    task automatic ref_prog(input logic [15:0] alo);
        ref_mem[alo[IDXW-1:0]] = ref_mem[alo[IDXW-1:0]] & {cur_dhi, cur_dlo};
    endtask

    task automatic ref_erase(input int sect);
        for (int i = 0; i < WORDS; i++) if ((i >> SW) == sect) ref_mem[i] = '1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '1;
        ref_prot = '1; ref_err = 1'b0;
        cur_alo = 0; cur_ahi = 0; cur_dlo = 0; cur_dhi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 suspended", 32'(suspended), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 ctl_o", 32'(ctl_o), 0);
        chk("R1 prot_word", prot_word, 32'hFFFF_FFFF);
        check_array("R1 array erased");

        // R2 word program, R12 register map
        load(16'd5, 16'd0, 16'h1234, 16'hA5A5);
        bcnt = 0;
        wr(3'd0, 16'h8001);
        wait_idle();
        ref_prog(16'd5);
        chk("R2 busy length", 32'(bcnt), PC);
        chk("R2 start cleared", 32'(ctl_o[15]), 0);
        chk("R2 err", 32'(err), 0);
        check_array("R2 array after program");

        // R11 writes while busy are ignored
        load(16'd6, 16'd0, 16'h00FF, 16'hF0F0);
        wr(3'd0, 16'h8001);
        wr(3'd1, 16'd7);
        wr(3'd0, 16'h8004);
        wait_idle();
        ref_prog(16'd6);
        chk("R11 suspend during program ignored", 32'(suspended), 0);
        wr(3'd3, 16'hFF0F);
        wr(3'd0, 16'h8001);
        wait_idle();
        ref_prog(16'd6);
        check_array("R11 address write during busy ignored");

        // R3 sector erase
        wr(3'd1, 16'd2);
        bcnt = 0;
        wr(3'd0, 16'h8002);
        wait_idle();
        ref_erase(0);
        chk("R3 busy length", 32'(bcnt), EC);
        check_array("R3 sector 0 erased");

        // R4 protection write ignores address
        load(16'hFFFF, 16'h1234, 16'hFFF0, 16'h7FFF);
        bcnt = 0;
        wr(3'd0, 16'h8100);
        wait_idle();
        ref_prot = ref_prot & 32'h7FFF_FFF0;
        chk("R4 prot_word", prot_word, ref_prot);
        chk("R4 busy length", 32'(bcnt), PC);
        chk("R4 err", 32'(err), 0);

        // R5 R6 R7 R8 R9 R10 suspend sequence on sector 1
        load(16'd9, 16'd0, 16'h0F0F, 16'h0000);
        wr(3'd0, 16'h8001); wait_idle(); ref_prog(16'd9);
        wr(3'd1, 16'd10); wr(3'd0, 16'h8001); wait_idle(); ref_prog(16'd10);
        wr(3'd1, 16'd8);
        bcnt = 0;
        wr(3'd0, 16'h8002);
        repeat (5) @(negedge clk);
        wr(3'd0, 16'h8006);
        chk("R5 suspended", 32'(suspended), 1);
        chk("R5 busy dropped", 32'(busy), 0);
        chk("R5 start cleared", 32'(ctl_o[15]), 0);
        repeat (30) @(negedge clk);
        chk("R5 still paused", 32'(suspended), 1);
        check_array("R5 sector unchanged while paused");
        wr(3'd0, 16'h8005);
        chk("R8 go with suspend err", 32'(err), 1);
        chk("R8 stays paused", 32'(suspended), 1);
        chk("R8 start bit stored clear", 32'(ctl_o), 32'h0005);
        wr(3'd0, 16'h0000);
        chk("R10 plain write keeps err", 32'(err), 1);
        wr(3'd1, 16'd3); wr(3'd3, 16'hAAAA); wr(3'd4, 16'h5555);
        wr(3'd0, 16'h8001);
        chk("R6 busy during paused program", 32'(busy && suspended), 1);
        chk("R10 err cleared by launch", 32'(err), 0);
        wait_idle();
        ref_prog(16'd3);
        chk("R6 back to paused", 32'(suspended), 1);
        check_array("R6 only target word changed");
        wr(3'd0, 16'h8100);
        chk("R9 protection launch while paused", 32'(err), 1);
        chk("R9 prot unchanged", prot_word, ref_prot);
        wr(3'd0, 16'h0002);
        chk("R7 resumed busy", 32'(busy && !suspended), 1);
        chk("R10 err cleared by resume", 32'(err), 0);
        wait_idle();
        ref_erase(1);
        chk("R7 total erase cycles", 32'(bcnt), EC);
        check_array("R7 sector 1 erased, word 3 kept");

        // R9 rejects from idle
        wr(3'd0, 16'h8000);
        chk("R9 no operation", 32'(err), 1);
        wr(3'd1, 16'd4); wr(3'd0, 16'h8001);
        chk("R10 accepted clears err", 32'(err), 0);
        wait_idle(); ref_prog(16'd4);
        wr(3'd0, 16'h8003);
        chk("R9 two operations", 32'(err), 1);
        wr(3'd2, 16'd1); wr(3'd0, 16'h8001);
        chk("R9 address high nonzero", 32'(err), 1);
        chk("R9 not busy", 32'(busy), 0);
        wr(3'd2, 16'd0); wr(3'd1, 16'h0040); wr(3'd0, 16'h8002);
        chk("R9 address low out of range", 32'(err), 1);
        check_array("R9 array unchanged by rejects");

        // random launches
        for (int it = 0; it < 60; it++) begin
            int kind, vd, expc;
            logic [15:0] alo, ahi, v;
            kind = int'($urandom_range(0, 4));
            alo  = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'($urandom_range(0, WORDS - 1));
            ahi  = ($urandom_range(0, 9) == 0) ? 16'd1 : 16'd0;
            case (kind)
                0, 1: v = 16'h8001;
                2:    v = 16'h8002;
                3:    v = 16'h8100;
                default: v = 16'($urandom);
            endcase
            load(alo, ahi, 16'($urandom), 16'($urandom));
            bcnt = 0;
            wr(3'd0, v);
            wait_idle();
            vd = idle_verdict(v, alo, ahi);
            expc = 0;
            case (vd)
                1: begin ref_prog(alo); ref_err = 1'b0; expc = PC; end
                2: begin ref_erase(int'(alo[IDXW-1:SW])); ref_err = 1'b0; expc = EC; end
                3: begin ref_prot = ref_prot & {cur_dhi, cur_dlo}; ref_err = 1'b0; expc = PC; end
                4: ref_err = 1'b1;
                default: ;
            endcase
            chk("R9 random err", 32'(err), 32'(ref_err));
            chk("R2 random busy length", 32'(bcnt), 32'(expc));
            chk("R10 random ctl_o", 32'(ctl_o), 32'(v & 16'h7FFF));
            chk("R4 random prot", prot_word, ref_prot);
            check_array("R3 random array");
        end

        finish_run();
    end
endmodule